// File: doc/BRIEF.md
# Branch-First Two-Level Issue Selector

This block decides, every cycle, which entries of a position-ordered issue queue are sent to execution. A lower slot index always means an older instruction. Each slot presents a request bit, which is set when the entry is valid and all of its sources are ready, and a flag that marks jumps and branches. The block returns one-hot grant vectors: one for a dedicated branch port that feeds a separate branch execution unit, and one for each of several general-purpose ports.

The branch port is resolved first. It takes the oldest requesting branch, and that slot is then removed from the general selection. The general ports are filled by a two-level tree. The slots are cut into equal groups. Every group selects its own oldest few requests in parallel, and a second level picks the final winners from the short list of group candidates. The result is the same as a single oldest-first scan, but the priority chain is much shorter. All grants are registered, so they appear on the clock edge after the requests are sampled.

Top module: `branch_first_issue_select`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the branch grant and all general grants are zero, whatever the inputs are.
- R2: Grants are registered. Request and flag values sampled at a rising edge produce their grants just after that same edge, and the grants stay unchanged until the next edge.
- R3: The branch grant has exactly one bit set, at the lowest-index slot whose request bit and branch flag are both 1, whenever such a slot exists.
- R4: When no requesting slot carries the branch flag, the branch grant is zero. A slot with the branch flag at 0 is never granted on the branch port.
- R5: The slot granted on the branch port is excluded from every general port in the same cycle.
- R6: General port 0 is granted the lowest-index requesting slot left after the branch removal, and port 1 the next lowest. A ready branch younger than the branch-port winner counts as an ordinary candidate.
- R7: When fewer candidates remain than there are general ports, the unused ports are zero, and a general port is only nonzero if every lower-numbered port is nonzero.
- R8: Every grant vector is one-hot or zero, and no slot is granted on more than one port.
- R9: The two-level result equals a global oldest-first scan in all cases, including when all winners come from one group, when they are spread across groups, and for any legal group size and port count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| reqVec | input | NUM_SLOTS | Per-slot request bit: the entry is valid and its sources are ready (bit 0 is the oldest) |
| brFlag | input | NUM_SLOTS | Per-slot bit that marks a jump or branch |
| brGrant | output | NUM_SLOTS | One-hot or zero grant for the branch port |
| genGrant | output | NUM_GEN_PORTS*NUM_SLOTS | General grants; bits [p*NUM_SLOTS +: NUM_SLOTS] belong to port p |

## Verification
The bench builds two copies of the block. The first uses the default 16 slots, 4 groups of 4 and 2 general ports. This is where the directed cases reach both winners inside one group, winners split across groups, and interaction with the branch mask. The second copy uses 8 slots in groups of 2 with 3 general ports. There, a group is smaller than the port count, so each group's whole contents must be passed up and the third port is exercised. Both copies are compared against an oldest-first scan model on directed and pseudo-random patterns.

// File: rtl/issue_sel_pkg.sv
package issue_sel_pkg;

  // Strobes from the branch control to the selection datapath
  typedef struct packed {
    logic brFire;   // some requesting slot carries the branch flag
    logic genOpen;  // at least one candidate is left for the general ports
  } selStrobe_t;

endpackage

// File: rtl/issue_sel_ctrl.sv
module issue_sel_ctrl
  import issue_sel_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16
) (
  input  logic [NUM_SLOTS-1:0] reqVec,
  input  logic [NUM_SLOTS-1:0] brFlag,
  output logic [NUM_SLOTS-1:0] brOneHot,
  output logic [NUM_SLOTS-1:0] genCand,
  output selStrobe_t           strobe
);

  logic [NUM_SLOTS-1:0] brReady;

  always_comb begin
    brReady  = reqVec & brFlag;
    // isolate the lowest set bit: oldest ready branch
    brOneHot = brReady & (~brReady + NUM_SLOTS'(1));
    genCand  = reqVec & ~brOneHot;
    strobe.brFire  = |brReady;
    strobe.genOpen = |genCand;
  end

endmodule

// File: rtl/issue_sel_dp.sv
module issue_sel_dp
  import issue_sel_pkg::*;
#(
  parameter int unsigned NUM_SLOTS     = 16,
  parameter int unsigned GROUP_SIZE    = 4,
  parameter int unsigned NUM_GEN_PORTS = 2
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [NUM_SLOTS-1:0]                   brOneHot,
  input  logic [NUM_SLOTS-1:0]                   genCand,
  input  selStrobe_t                             strobe,
  output logic [NUM_SLOTS-1:0]                   brGrantQ,
  output logic [NUM_GEN_PORTS-1:0][NUM_SLOTS-1:0] genGrantQ
);

  localparam int unsigned NUM_GROUPS = NUM_SLOTS / GROUP_SIZE;
  localparam int unsigned IDX_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int unsigned PICKS      = (NUM_GEN_PORTS < GROUP_SIZE) ? NUM_GEN_PORTS : GROUP_SIZE;
  localparam int unsigned NUM_CAND   = NUM_GROUPS * PICKS;

  logic [NUM_CAND-1:0]       candValid;
  logic [NUM_CAND*IDX_W-1:0] candIdx;

  // First level: each group hands up its PICKS oldest requests
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    logic [PICKS-1:0]       lvlValid;
    logic [PICKS*IDX_W-1:0] lvlIdx;

    always_comb begin
      logic [GROUP_SIZE-1:0] rem;
      logic hit;
      rem = genCand[g*GROUP_SIZE +: GROUP_SIZE];
      for (int p = 0; p < PICKS; p++) begin
        hit = 1'b0;
        lvlIdx[p*IDX_W +: IDX_W] = '0;
        for (int s = 0; s < GROUP_SIZE; s++) begin
          if (rem[s] && !hit) begin
            hit = 1'b1;
            rem[s] = 1'b0;
            lvlIdx[p*IDX_W +: IDX_W] = IDX_W'(g*GROUP_SIZE + s);
          end
        end
        lvlValid[p] = hit;
      end
    end

    assign candValid[g*PICKS +: PICKS]             = lvlValid;
    assign candIdx[g*PICKS*IDX_W +: PICKS*IDX_W]   = lvlIdx;
  end

  // Second level: candidates are already in age order (group-major)
  logic [NUM_GEN_PORTS-1:0][NUM_SLOTS-1:0] genNext;

  always_comb begin
    logic [NUM_CAND-1:0] taken;
    logic hit;
    taken   = '0;
    genNext = '0;
    for (int p = 0; p < NUM_GEN_PORTS; p++) begin
      hit = 1'b0;
      for (int c = 0; c < NUM_CAND; c++) begin
        if (candValid[c] && !taken[c] && !hit) begin
          hit = 1'b1;
          taken[c] = 1'b1;
          genNext[p][candIdx[c*IDX_W +: IDX_W]] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brGrantQ  <= '0;
      genGrantQ <= '0;
    end else begin
      brGrantQ  <= strobe.brFire  ? brOneHot : '0;
      genGrantQ <= strobe.genOpen ? genNext  : '0;
    end
  end

endmodule

// File: rtl/branch_first_issue_select.sv
module branch_first_issue_select
  import issue_sel_pkg::*;
#(
  parameter int unsigned NUM_SLOTS     = 16,
  parameter int unsigned GROUP_SIZE    = 4,
  parameter int unsigned NUM_GEN_PORTS = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_SLOTS-1:0]               reqVec,
  input  logic [NUM_SLOTS-1:0]               brFlag,
  output logic [NUM_SLOTS-1:0]               brGrant,
  output logic [NUM_GEN_PORTS*NUM_SLOTS-1:0] genGrant
);

  logic [NUM_SLOTS-1:0]                    brOneHot;
  logic [NUM_SLOTS-1:0]                    genCand;
  selStrobe_t                              strobe;
  logic [NUM_GEN_PORTS-1:0][NUM_SLOTS-1:0] genGrantQ;

  issue_sel_ctrl #(.NUM_SLOTS(NUM_SLOTS)) uCtrl (
    .reqVec   (reqVec),
    .brFlag   (brFlag),
    .brOneHot (brOneHot),
    .genCand  (genCand),
    .strobe   (strobe)
  );

  issue_sel_dp #(
    .NUM_SLOTS     (NUM_SLOTS),
    .GROUP_SIZE    (GROUP_SIZE),
    .NUM_GEN_PORTS (NUM_GEN_PORTS)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .brOneHot  (brOneHot),
    .genCand   (genCand),
    .strobe    (strobe),
    .brGrantQ  (brGrant),
    .genGrantQ (genGrantQ)
  );

  assign genGrant = genGrantQ;

endmodule

// File: rtl/issue_sel_checker.sv
module issue_sel_checker #(
  parameter int unsigned NUM_SLOTS     = 16,
  parameter int unsigned GROUP_SIZE    = 4,
  parameter int unsigned NUM_GEN_PORTS = 2
) (
  input logic                               clk,
  input logic                               rstN,
  input logic [NUM_SLOTS-1:0]               reqVec,
  input logic [NUM_SLOTS-1:0]               brFlag,
  input logic [NUM_SLOTS-1:0]               brGrant,
  input logic [NUM_GEN_PORTS*NUM_SLOTS-1:0] genGrant
);

  logic [NUM_SLOTS-1:0] orAll;
  int unsigned          bitTotal;

  always_comb begin
    orAll    = brGrant;
    bitTotal = $countones(brGrant);
    for (int p = 0; p < NUM_GEN_PORTS; p++) begin
      orAll    = orAll | genGrant[p*NUM_SLOTS +: NUM_SLOTS];
      bitTotal = bitTotal + $countones(genGrant[p*NUM_SLOTS +: NUM_SLOTS]);
    end
  end

  // R8: branch port one-hot or zero
  p_br_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(brGrant));

  // R8: no slot appears on two ports
  p_no_shared_slot_r8: assert property (@(posedge clk) disable iff (!rstN)
    bitTotal == $countones(orAll));

  // R4: branch port only carries a slot that was a ready branch
  p_br_only_branch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (brGrant & ~($past(reqVec) & $past(brFlag))) == '0);

  // R3: a ready branch at the sampling edge gives a branch grant
  p_br_fires_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((reqVec & brFlag) != '0) |=> (brGrant != '0));

  // R2: general grants only cover slots that requested
  p_gen_from_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((orAll & ~brGrant) & ~$past(reqVec)) == '0);

  for (genvar p = 0; p < NUM_GEN_PORTS; p++) begin : gPort
    // R8: each general port one-hot or zero
    p_gen_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(genGrant[p*NUM_SLOTS +: NUM_SLOTS]));
    if (p > 0) begin : gOrder
      // R7: a port is used only when the port below it is used
      p_port_order_r7: assert property (@(posedge clk) disable iff (!rstN)
        (genGrant[p*NUM_SLOTS +: NUM_SLOTS] != '0) |->
        (genGrant[(p-1)*NUM_SLOTS +: NUM_SLOTS] != '0));
    end
  end

endmodule

bind branch_first_issue_select issue_sel_checker #(
  .NUM_SLOTS     (NUM_SLOTS),
  .GROUP_SIZE    (GROUP_SIZE),
  .NUM_GEN_PORTS (NUM_GEN_PORTS)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqVec   (reqVec),
  .brFlag   (brFlag),
  .brGrant  (brGrant),
  .genGrant (genGrant)
);

// File: tb/tb_branch_first_issue_select.sv
module tb_branch_first_issue_select;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] reqVec = '0;
  logic [15:0] brFlag = '0;
  logic [15:0] brGrant;
  logic [31:0] genGrant;
  logic [7:0]  reqVec2 = '0;
  logic [7:0]  brFlag2 = '0;
  logic [7:0]  brGrant2;
  logic [23:0] genGrant2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  branch_first_issue_select #(.NUM_SLOTS(16), .GROUP_SIZE(4), .NUM_GEN_PORTS(2)) dut (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .brFlag(brFlag),
    .brGrant(brGrant), .genGrant(genGrant));

  branch_first_issue_select #(.NUM_SLOTS(8), .GROUP_SIZE(2), .NUM_GEN_PORTS(3)) dut2 (
    .clk(clk), .rstN(rstN), .reqVec(reqVec2), .brFlag(brFlag2),
    .brGrant(brGrant2), .genGrant(genGrant2));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Oldest-first scan model
  task automatic refModel(input logic [15:0] req, input logic [15:0] br, input int n,
                          input int ports, output logic [15:0] expBr,
                          output logic [15:0] expGen [3]);
    logic [15:0] rem;
    logic found;
    expBr = '0;
    found = 1'b0;
    for (int s = 0; s < n; s++)
      if (req[s] && br[s] && !found) begin expBr[s] = 1'b1; found = 1'b1; end
    rem = req & ~expBr;
    for (int p = 0; p < 3; p++) begin
      expGen[p] = '0;
      found = 1'b0;
      if (p < ports)
        for (int s = 0; s < n; s++)
          if (rem[s] && !found) begin expGen[p][s] = 1'b1; rem[s] = 1'b0; found = 1'b1; end
    end
  endtask

  // Drive at a falling edge, compare after the next rising edge
  task automatic step(input logic [15:0] req, input logic [15:0] br, input string tag);
    logic [15:0] eb;
    logic [15:0] eg [3];
    logic [15:0] eb2;
    logic [15:0] eg2 [3];
    @(negedge clk);
    reqVec = req; brFlag = br; reqVec2 = req[7:0]; brFlag2 = br[7:0];
    @(negedge clk);
    refModel(req, br, 16, 2, eb, eg);
    refModel({8'h00, req[7:0]}, {8'h00, br[7:0]}, 8, 3, eb2, eg2);
    check({tag, " brGrant"}, {16'h0, brGrant}, {16'h0, eb});
    check({tag, " port0"}, {16'h0, genGrant[15:0]}, {16'h0, eg[0]});
    check({tag, " port1"}, {16'h0, genGrant[31:16]}, {16'h0, eg[1]});
    check({tag, " R9 small brGrant"}, {24'h0, brGrant2}, {24'h0, eb2[7:0]});
    check({tag, " R9 small gen"}, {8'h0, genGrant2}, {8'h0, eg2[2][7:0], eg2[1][7:0], eg2[0][7:0]});
  endtask

  task automatic testReset;
    reqVec = 16'hffff; brFlag = 16'h00f0; reqVec2 = 8'hff; brFlag2 = 8'h0f;
    repeat (2) @(negedge clk);
    check("R1 reset brGrant", {16'h0, brGrant}, 32'h0);
    check("R1 reset genGrant", genGrant, 32'h0);
    check("R1 reset small", {brGrant2, genGrant2}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    reqVec = '0; brFlag = '0; reqVec2 = '0; brFlag2 = '0;
  endtask

  task automatic testBranchPick;
    step(16'h0120, 16'h0100, "R3 single branch");
    step(16'h8421, 16'h8420, "R3 oldest of several branches");
    step(16'h1000, 16'h1000, "R3 lone branch high slot");
  endtask

  task automatic testNoBranch;
    step(16'h00c3, 16'h0000, "R4 no branch flag");
    step(16'h0011, 16'h0f00, "R4 flags only on idle slots");
  endtask

  task automatic testMask;
    step(16'h0007, 16'h0001, "R5 branch in slot 0 masked");
    step(16'h0006, 16'h0006, "R6 younger branch on general port");
  endtask

  task automatic testGroups;
    step(16'h0f00, 16'h0000, "R9 both winners in one group");
    step(16'h8080, 16'h0000, "R9 winners in distant groups");
    step(16'hfffe, 16'h0000, "R6 full queue");
  endtask

  task automatic testFewRequests;
    step(16'h0400, 16'h0000, "R7 single request");
    step(16'h0000, 16'h0000, "R7 empty");
    step(16'h0002, 16'h0002, "R7 only a branch");
  endtask

  task automatic testLatency;
    step(16'h0030, 16'h0000, "R2 prior value");
    @(negedge clk);
    reqVec = 16'h0300; brFlag = 16'h0000;
    #2;
    check("R2 held before edge", genGrant, {16'h0020, 16'h0010});
    @(negedge clk);
    check("R2 updated after edge", genGrant, {16'h0200, 16'h0100});
  endtask

  task automatic testRandom;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] r;
      logic [15:0] b;
      r = 16'($urandom);
      b = 16'($urandom) & 16'($urandom);
      step(r, b, "R8 random vs scan");
    end
  endtask

  initial begin
    testReset();
    testBranchPick();
    testNoBranch();
    testMask();
    testGroups();
    testFewRequests();
    testLatency();
    testRandom();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule